// File: doc/BRIEF.md
# EDID Read Responder with Display-Controller Register Interface

This block sits behind a four-register bus window and answers a display driver as if a monitor's EDID were being read over an I2C display channel. The driver picks a pin, writes a command word naming the EDID target, a start index, a byte count and a cycle type, and then reads the data register repeatedly. Each data read pulls up to four bytes from a 128-byte EDID store and packs them into the data word, least significant byte first. No serial bus is driven. Register writes move a small phase machine (idle, data, wait) directly, and status bits follow the handshakes a real controller would show.

The EDID store is filled through a byte-wide load port. A per-pin presence vector says which pins have a monitor attached. The current bus phase is brought out on its own port. Register offsets are 0 for pin select, 1 for command, 2 for status and 3 for data. Reads return their value one cycle after the read strobe. A write takes precedence if both strobes are high.

Top module: `edid_i2c_resp`

## Requirements
- R1: After reset, status reads 0x0C00 (hardware-ready bit 11 and error bit 10), the phase is idle (code 0), and the data register reads 0.
- R2: Writing a nonzero pin select (bits 2:0) clears the transfer context and the active bit 9, sets hardware-ready and the wait-status bit 14, and clears the error bit when that pin's presence input is high, otherwise sets it. A pin value of 0 clears the context and leaves status unchanged.
- R3: Command fields are read direction in bit 0, target address in bits 7:1, start index in bits 15:8, byte count in bits 24:16, cycle type in bits 27:25, software-ready in bit 30 and clear-interrupt in bit 31. Only target address 0x50 selects the EDID. Software-ready always reads back as 0.
- R4: When command bit 26 (the index-enable bit) is set, the read pointer is loaded from the start index.
- R5: Cycle codes are: 0 none; 1 data, no index, wait end; 3 data, index, wait end; 5 data, no index, stop end; 7 data, index, stop end; 4 stop. A data cycle sets phase data (code 1) and the active bit. A stop whose preceding command cycle was not none clears the context and the active bit, and sets phase idle. A stop after a none cycle changes nothing.
- R6: With the read bit set and bytes remaining (count minus pointer) greater than zero, a data read fetches min(remaining, 4) bytes into byte lanes 0 upward. The lanes above them keep their previous contents.
- R7: A data read with no bytes remaining returns the previous data value unchanged.
- R8: A data read that takes the final bytes (remaining ≤ 4) sets phase idle for cycle types 5 and 7, or phase wait (code 2) for types 1 and 3. It then clears the selection, availability, pointer and count.
- R9: A status read returns the value held before the read and then sets the in-use bit 15. Writing a 1 to bit 15 clears it. All other status bits ignore writes.
- R10: A command write with bit 31 set, while it is not latched, clears the interrupt bit 12, sets hardware-ready, and latches bit 31. The next command write with bit 31 clear unlatches it, sets status to hardware-ready (plus the error bit if no EDID is available) and phase idle, and otherwise has no effect.
- R11: A fetched byte is 0 and the pointer does not advance when the target is not selected, the pointer is 128 or more, or no EDID is available.
- R12: With the read bit clear, a data read returns the previous data value and consumes nothing. Writes to the data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| mon_present | input | NUM_PINS | Monitor present per pin select value |
| edid_ld_en | input | 1 | EDID store byte write enable |
| edid_ld_addr | input | log2(EDID_BYTES) | EDID store byte address |
| edid_ld_data | input | 8 | EDID store byte |
| bus_phase | output | 2 | Current phase: 0 idle, 1 data, 2 wait |

## Verification
The assertions check invariants on every cycle. The data phase always has the active bit set. Software-ready is never stored. A status read always leaves in-use set. The clear-interrupt handshake always raises hardware-ready. The read pointer and read data stay put unless a data read or a write occurs. Byte packing with partial upper-lane preservation, the split between stop-ended and wait-ended transfers, the edge at pointer 128, unselected and unavailable targets, and the full latch/unlatch sequence can only be shown by the bench. The bench compares every data word against a byte-level model of the EDID contents.

// File: rtl/edid_resp_pkg.sv
package edid_resp_pkg;

    localparam logic [1:0] A_PIN  = 2'd0;
    localparam logic [1:0] A_CMD  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    localparam int CMD_RD     = 0;
    localparam int CMD_IDXEN  = 26;
    localparam int CMD_SWRDY  = 30;
    localparam int CMD_CLRINT = 31;

    localparam int ST_ACTIVE = 9;
    localparam int ST_ERR    = 10;
    localparam int ST_HWRDY  = 11;
    localparam int ST_INT    = 12;
    localparam int ST_WAIT   = 14;
    localparam int ST_INUSE  = 15;

    localparam logic [31:0] M_HWRDY = 32'h1 << ST_HWRDY;
    localparam logic [31:0] M_ERR   = 32'h1 << ST_ERR;

    localparam logic [6:0] EDID_TARGET = 7'h50;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        CY_NONE   = 3'd0,
        CY_NIDX_W = 3'd1,
        CY_RSV2   = 3'd2,
        CY_IDX_W  = 3'd3,
        CY_STOP   = 3'd4,
        CY_NIDX_S = 3'd5,
        CY_RSV6   = 3'd6,
        CY_IDX_S  = 3'd7
    } cycle_e;

    typedef struct packed {
        logic       sel;
        logic       avail;
        logic [7:0] ptr;
        logic [8:0] cnt;
        cycle_e     cyc;
    } ctx_t;

    typedef struct packed {
        logic       rd;
        logic [6:0] target;
        logic [7:0] index;
        logic [8:0] count;
        cycle_e     cyc;
        logic       idx_en;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [31:0] w);
        cmd_t c;
        c.rd     = w[CMD_RD];
        c.target = w[7:1];
        c.index  = w[15:8];
        c.count  = w[24:16];
        c.cyc    = cycle_e'(w[27:25]);
        c.idx_en = w[CMD_IDXEN];
        return c;
    endfunction

    function automatic logic is_data_cycle(input cycle_e c);
        return (c == CY_NIDX_W) || (c == CY_IDX_W) ||
               (c == CY_NIDX_S) || (c == CY_IDX_S);
    endfunction

    function automatic logic ends_with_stop(input cycle_e c);
        return (c == CY_NIDX_S) || (c == CY_IDX_S);
    endfunction

endpackage

// File: rtl/edid_store.sv
module edid_store #(
    parameter int DEPTH = 128,
    parameter int LANES = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               ld_en,
    input  logic [AW-1:0]      ld_addr,
    input  logic [7:0]         ld_data,
    input  logic [7:0]         rd_base,
    output logic [LANES*8-1:0] lane_bytes
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [AW-1:0] lane_addr;
        assign lane_addr = AW'(32'(rd_base) + g);
        assign lane_bytes[g*8 +: 8] = mem[lane_addr];
    end
endmodule

// File: rtl/edid_packer.sv
module edid_packer #(
    parameter int DEPTH = 128,
    parameter int LANES = 4,
    parameter int NW    = $clog2(LANES + 1)
) (
    input  logic [7:0]         ptr,
    input  logic [8:0]         cnt,
    input  logic               sel,
    input  logic               avail,
    input  logic [LANES*8-1:0] prev_word,
    input  logic [LANES*8-1:0] lane_bytes,
    output logic [LANES*8-1:0] word,
    output logic [NW-1:0]      adv,
    output logic               have_data,
    output logic               last
);
    logic signed [10:0] left;
    logic [NW-1:0]      take;

    always_comb begin
        left      = $signed({2'b00, cnt}) - $signed({3'b000, ptr});
        have_data = left > 0;
        last      = left <= LANES;
        take      = (left >= LANES) ? NW'(LANES) : left[NW-1:0];
        word      = prev_word;
        adv       = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(take)) begin
                if (sel && avail && (int'(ptr) + i < DEPTH)) begin
                    word[i*8 +: 8] = lane_bytes[i*8 +: 8];
                    adv            = adv + 1'b1;
                end else begin
                    word[i*8 +: 8] = 8'h00;
                end
            end
        end
    end
endmodule

// File: rtl/edid_i2c_resp.sv
module edid_i2c_resp
    import edid_resp_pkg::*;
#(
    parameter int EDID_BYTES = 128,
    parameter int NUM_PINS   = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [1:0]                    bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_PINS-1:0]           mon_present,
    input  logic                          edid_ld_en,
    input  logic [$clog2(EDID_BYTES)-1:0] edid_ld_addr,
    input  logic [7:0]                    edid_ld_data,
    output logic [1:0]                    bus_phase
);
    localparam int LANES = 4;
    localparam int NW    = $clog2(LANES + 1);
    localparam int PIN_W = $clog2(NUM_PINS);

    logic [31:0] pin_q, cmd_q, stat_q, data_q;
    ctx_t        ctx;
    phase_e      phase;

    logic [31:0]        cmd_wv;
    cmd_t               cmd_in;
    logic [PIN_W-1:0]   pin_in;
    logic [LANES*8-1:0] lane_bytes, pk_word;
    logic [NW-1:0]      pk_adv;
    logic               pk_have, pk_last;

    always_comb begin
        cmd_wv            = bus_wdata;
        cmd_wv[CMD_SWRDY] = 1'b0;
        cmd_in            = decode_cmd(cmd_wv);
        pin_in            = bus_wdata[PIN_W-1:0];
    end

    edid_store #(.DEPTH(EDID_BYTES), .LANES(LANES)) u_store (
        .clk       (clk),
        .ld_en     (edid_ld_en),
        .ld_addr   (edid_ld_addr),
        .ld_data   (edid_ld_data),
        .rd_base   (ctx.ptr),
        .lane_bytes(lane_bytes)
    );

    edid_packer #(.DEPTH(EDID_BYTES), .LANES(LANES)) u_pack (
        .ptr       (ctx.ptr),
        .cnt       (ctx.cnt),
        .sel       (ctx.sel),
        .avail     (ctx.avail),
        .prev_word (data_q),
        .lane_bytes(lane_bytes),
        .word      (pk_word),
        .adv       (pk_adv),
        .have_data (pk_have),
        .last      (pk_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q     <= '0;
            cmd_q     <= '0;
            stat_q    <= M_HWRDY | M_ERR;
            data_q    <= '0;
            ctx       <= '0;
            phase     <= PH_IDLE;
            bus_rdata <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_PIN: begin
                    pin_q <= bus_wdata;
                    ctx   <= '0;
                    if (pin_in != '0) begin
                        phase             <= PH_IDLE;
                        stat_q[ST_ACTIVE] <= 1'b0;
                        stat_q[ST_HWRDY]  <= 1'b1;
                        stat_q[ST_WAIT]   <= 1'b1;
                        if (mon_present[pin_in]) begin
                            ctx.avail      <= 1'b1;
                            stat_q[ST_ERR] <= 1'b0;
                        end else begin
                            stat_q[ST_ERR] <= 1'b1;
                        end
                    end
                end
                A_CMD: begin
                    if (cmd_q[CMD_CLRINT]) begin
                        if (!bus_wdata[CMD_CLRINT]) begin
                            cmd_q[CMD_CLRINT] <= 1'b0;
                            stat_q <= M_HWRDY | (ctx.avail ? 32'h0 : M_ERR);
                            phase  <= PH_IDLE;
                        end
                    end else begin
                        if (bus_wdata[CMD_CLRINT]) begin
                            stat_q[ST_INT]   <= 1'b0;
                            stat_q[ST_HWRDY] <= 1'b1;
                        end
                        ctx.cnt <= cmd_in.count;
                        ctx.cyc <= cmd_in.cyc;
                        if (cmd_in.target == EDID_TARGET) ctx.sel <= 1'b1;
                        if (cmd_in.idx_en) ctx.ptr <= cmd_in.index;
                        if (cmd_in.cyc == CY_STOP) begin
                            if (cycle_e'(cmd_q[27:25]) != CY_NONE) begin
                                ctx               <= '0;
                                phase             <= PH_IDLE;
                                stat_q[ST_ACTIVE] <= 1'b0;
                            end
                        end else if (is_data_cycle(cmd_in.cyc)) begin
                            phase             <= PH_DATA;
                            stat_q[ST_ACTIVE] <= 1'b1;
                        end
                        cmd_q <= cmd_wv;
                    end
                end
                A_STAT: begin
                    if (bus_wdata[ST_INUSE]) stat_q[ST_INUSE] <= 1'b0;
                end
                default: ;
            endcase
        end else if (bus_rd) begin
            case (bus_addr)
                A_PIN:  bus_rdata <= pin_q;
                A_CMD:  bus_rdata <= cmd_q;
                A_STAT: begin
                    bus_rdata         <= stat_q;
                    stat_q[ST_INUSE]  <= 1'b1;
                end
                default: begin
                    if (cmd_q[CMD_RD] && pk_have) begin
                        data_q    <= pk_word;
                        bus_rdata <= pk_word;
                        ctx.ptr   <= ctx.ptr + 8'(pk_adv);
                        if (pk_last) begin
                            phase <= ends_with_stop(ctx.cyc) ? PH_IDLE : PH_WAIT;
                            ctx   <= '0;
                        end
                    end else begin
                        bus_rdata <= data_q;
                    end
                end
            endcase
        end
    end

    assign bus_phase = phase;

    assert_active_in_data_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> stat_q[ST_ACTIVE]);

    assert_swrdy_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CMD && !cmd_q[CMD_CLRINT]) |=> !cmd_q[CMD_SWRDY]);

    assert_inuse_after_read_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == A_STAT) |=> stat_q[ST_INUSE]);

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    assert_clrint_ready_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CMD && !cmd_q[CMD_CLRINT] && bus_wdata[CMD_CLRINT])
        |=> (stat_q[ST_HWRDY] && !stat_q[ST_INT] && cmd_q[CMD_CLRINT]));

    assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !(bus_rd && bus_addr == A_DATA)) |=> $stable(ctx.ptr));
endmodule

// File: tb/tb_edid_i2c_resp.sv
`timescale 1ns/1ps
module tb_edid_i2c_resp;
    localparam logic [1:0] A_PIN = 2'd0, A_CMD = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  mon_present = 8'b0000_0010;
    logic        edid_ld_en = 1'b0;
    logic [6:0]  edid_ld_addr = '0;
    logic [7:0]  edid_ld_data = '0;
    logic [1:0]  bus_phase;

    always #4 clk = ~clk;

    edid_i2c_resp dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mon_present(mon_present), .edid_ld_en(edid_ld_en),
        .edid_ld_addr(edid_ld_addr), .edid_ld_data(edid_ld_data),
        .bus_phase(bus_phase)
    );

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [7:0]  mem_m [128];
    int          m_ptr, m_cnt, m_exph;
    bit          m_sel, m_avail, m_rdbit;
    logic [2:0]  m_cyc, m_prevcyc;
    logic [31:0] m_prev;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic rd_stat(output logic [31:0] d);
        wr(A_STAT, 32'h0000_8000);
        rd(A_STAT, d);
    endtask

    function automatic logic [31:0] mk_cmd(input bit rdb, input logic [6:0] ta,
        input logic [7:0] idx, input logic [8:0] cnt, input logic [2:0] cyc);
        return {4'b0000, cyc, cnt, idx, ta, rdb};
    endfunction

    task automatic clear_ctx();
        m_sel = 0; m_avail = 0; m_ptr = 0; m_cnt = 0; m_cyc = 0;
    endtask

    task automatic mpin(input int p);
        wr(A_PIN, 32'(p));
        clear_ctx();
        m_avail = (p != 0) && mon_present[p];
    endtask

    task automatic mcmd(input logic [31:0] w);
        wr(A_CMD, w);
        m_cnt = int'(w[24:16]);
        if (w[7:1] == 7'h50) m_sel = 1;
        if (w[26]) m_ptr = int'(w[15:8]);
        m_cyc = w[27:25];
        if (w[27:25] == 3'd4 && m_prevcyc != 3'd0) clear_ctx();
        m_prevcyc = w[27:25];
        m_rdbit = w[0];
    endtask

    task automatic mread(input string req, output bit done);
        logic [31:0] exp, got;
        int left, n;
        bit ok;
        done = 0;
        exp = m_prev;
        if (m_rdbit) begin
            left = m_cnt - m_ptr;
            if (left > 0) begin
                n = (left > 4) ? 4 : left;
                for (int i = 0; i < n; i++) begin
                    ok = m_sel && m_avail && (m_ptr < 128);
                    exp[i*8 +: 8] = ok ? mem_m[m_ptr] : 8'h00;
                    if (ok) m_ptr++;
                end
                if (left <= 4) begin
                    done = 1;
                    m_exph = m_cyc[2] ? 0 : 2;
                    clear_ctx();
                end
            end
        end
        m_prev = exp;
        rd(A_DATA, got);
        chk(req, got, exp);
        if (done) chk({req, " end phase"}, 32'(bus_phase), 32'(m_exph));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit done;
        void'($urandom(32'd1234));
        m_prev = '0; m_prevcyc = '0; m_rdbit = 0; m_exph = 0;
        clear_ctx();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 128; i++) begin
            mem_m[i] = 8'($urandom);
            @(negedge clk);
            edid_ld_en = 1'b1; edid_ld_addr = 7'(i); edid_ld_data = mem_m[i];
        end
        @(negedge clk); edid_ld_en = 1'b0;

        // R1 reset state
        rd(A_STAT, v); chk("R1 status", v, 32'h0000_0C00);
        chk("R1 phase", 32'(bus_phase), 32'd0);
        rd(A_DATA, v); chk("R1 data", v, 32'h0);

        // R9 in-use handshake
        rd(A_STAT, v); chk("R9 inuse set after read", v, 32'h0000_8C00);
        wr(A_STAT, 32'h0000_7FFF);
        rd(A_STAT, v); chk("R9 other bits read-only", v, 32'h0000_8C00);
        wr(A_STAT, 32'h0000_8000);
        rd(A_STAT, v); chk("R9 write one clears", v, 32'h0000_0C00);

        // R2 pin select
        mpin(2); rd_stat(v); chk("R2 absent pin", v, 32'h0000_4C00);
        mpin(1); rd_stat(v); chk("R2 present pin", v, 32'h0000_4800);
        mpin(0); rd_stat(v); chk("R2 zero pin", v, 32'h0000_4800);

        // R5 R6 R7 R8 stop-ended transfer with index (R4)
        mpin(1);
        mcmd(mk_cmd(1, 7'h50, 8'd10, 9'd16, 3'd7));
        chk("R5 data phase", 32'(bus_phase), 32'd1);
        rd_stat(v); chk("R5 active set", v, 32'h0000_4A00);
        mread("R6 R4 four bytes", done);
        mread("R6 two bytes upper kept", done); chk("R8 stop end done", 32'(done), 32'd1);
        mread("R7 nothing left", done);

        // R8 wait-ended transfer, R5 stop rules
        mpin(1);
        mcmd(mk_cmd(1, 7'h50, 8'd0, 9'd3, 3'd3));
        mread("R8 wait end", done);
        mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd0));
        mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd4));
        chk("R5 stop after none ignored", 32'(bus_phase), 32'd2);
        mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd1));
        chk("R5 data cycle", 32'(bus_phase), 32'd1);
        mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd4));
        chk("R5 stop to idle", 32'(bus_phase), 32'd0);
        rd_stat(v); chk("R5 active cleared", v & 32'h200, 32'h0);

        // R3 R11 unselected target
        mpin(1);
        mcmd(mk_cmd(1, 7'h51, 8'd0, 9'd8, 3'd7));
        mread("R3 R11 unselected zeros", done);
        mread("R11 no advance", done);
        mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd4));

        // R11 pointer edge at 128
        mpin(1);
        mcmd(mk_cmd(1, 7'h50, 8'd126, 9'd200, 3'd7));
        mread("R11 crossing 128", done);
        mread("R11 beyond 128", done);
        mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd4));

        // R11 unavailable EDID
        mpin(2);
        mcmd(mk_cmd(1, 7'h50, 8'd0, 9'd8, 3'd5));
        mread("R11 unavailable", done);
        mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd4));

        // R3 software-ready never stored
        mcmd(32'h4000_0000 | mk_cmd(0, 7'h50, 8'd3, 9'd5, 3'd0));
        rd(A_CMD, v); chk("R3 swrdy reads 0", v, mk_cmd(0, 7'h50, 8'd3, 9'd5, 3'd0));

        // R12 read bit clear, data writes ignored
        mpin(1);
        mcmd(mk_cmd(0, 7'h50, 8'd0, 9'd8, 3'd5));
        wr(A_DATA, 32'hDEAD_BEEF);
        mread("R12 no read bit", done);
        mcmd(mk_cmd(1, 7'h50, 8'd0, 9'd8, 3'd5));
        mread("R12 nothing consumed", done);
        mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd4));

        // R10 clear-interrupt latch
        mpin(1);
        wr(A_CMD, 32'h8000_0000);
        rd_stat(v); chk("R10 latch sets ready", v, 32'h0000_4800);
        rd(A_CMD, v); chk("R10 latch held", v, 32'h8000_0000);
        wr(A_CMD, mk_cmd(1, 7'h50, 8'd0, 9'd8, 3'd7));
        chk("R10 unlatch phase idle", 32'(bus_phase), 32'd0);
        rd_stat(v); chk("R10 reset with edid", v, 32'h0000_0800);
        rd(A_CMD, v); chk("R10 unlatch write ignored", v, 32'h0);
        mpin(2);
        wr(A_CMD, 32'h8000_0000);
        wr(A_CMD, 32'h0);
        rd_stat(v); chk("R10 reset without edid", v, 32'h0000_0C00);
        m_prevcyc = 3'd0; m_rdbit = 0;

        // random sessions
        for (int s = 0; s < 30; s++) begin
            int p, idx, cnt;
            logic [6:0] ta;
            logic [2:0] cyc;
            p   = ($urandom_range(0, 4) == 0) ? 2 : 1;
            ta  = ($urandom_range(0, 4) == 0) ? 7'h51 : 7'h50;
            idx = $urandom_range(0, 135);
            cnt = $urandom_range(0, 160);
            cyc = 3'(2 * $urandom_range(0, 3) + 1);
            mpin(p);
            mcmd(mk_cmd(1, ta, 8'(idx), 9'(cnt), cyc));
            done = 0;
            for (int k = 0; k < 45 && !done; k++) mread("R6 R8 R11 random", done);
            mcmd(mk_cmd(1, 7'h00, 8'd0, 9'd0, 3'd4));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule